// File: doc/BRIEF.md
# Common-Mode Restore Training Gate

This block sits beside the ordered-set transmitter of a serial link port while the link returns from a low-power state through recovery. It stops the transmitter from moving on to training set 2 (TS2) until the transmit common mode has had time to settle. Until then the transmitter keeps sending training set 1 (TS1). The settling time comes from an 8-bit control-register field and is counted in microseconds, one step for each pulse of a free-running microsecond tick.

Two events arm the timer: a TS1 going out and the receiver leaving squelch. Each event is latched while the port is in recovery, and the two may arrive in either order. Once both are held, microsecond ticks are counted until the count reaches the programmed time. At that point the gate raises a TS2-permit level and gives a one-cycle timer-done pulse. Leaving recovery clears all state, so the next recovery starts again from the beginning.

Top module: `cm_restore_gate`

## Requirements
- R1: After reset, `ts2Permit` and `timerDone` are low.
- R2: During recovery, `ts2Permit` stays low while a TS1 event (`ts1Sent` high) and un-squelch (`rxSquelched` low) have not both been latched, however many ticks arrive.
- R3: The two start events are latched at the clock edge where they are seen. They may occur in either order or in the same cycle, and the timer is armed from the cycle after the later one.
- R4: Only `usTick` cycles in which the timer is armed are counted, so a tick in the cycle that latches the last start event is not counted. `ts2Permit` goes high at the edge that ends the cycle of the counted tick whose number equals `cmTime`.
- R5: With `cmTime` equal to 0, `ts2Permit` goes high at the edge that ends the first armed cycle, without waiting for a tick.
- R6: Once high, `ts2Permit` stays high for as long as `inRecovery` stays high, whatever ticks or events follow.
- R7: A cycle with `inRecovery` low clears the permit, the count and both latched events at its closing edge. Events that occur while `inRecovery` is low are not latched.
- R8: `timerDone` is high for exactly one cycle: the first cycle in which `ts2Permit` is high.
- R9: `cmTime` is an unsigned 8-bit count of microseconds, and settings up to 255 ticks are honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-cycle pulse once per microsecond |
| ts1Sent | input | 1 | A TS1 ordered set has just been transmitted |
| rxSquelched | input | 1 | Receiver squelch status, high while squelched |
| inRecovery | input | 1 | Link training is in the recovery state |
| cmTime | input | 8 | Common-mode settling time in microseconds |
| ts2Permit | output | 1 | TS2 may be sent |
| timerDone | output | 1 | One-cycle pulse when the settling time expires |

## Verification
The assertions assume that `cmTime` does not change between arming and expiry, and that `usTick` is a single-cycle strobe. Without these, a rise of the permit on a nonzero setting could not be tied to a tick in the cycle before it. The stimulus changes `cmTime` only while `inRecovery` is low and drives ticks as isolated pulses, either every cycle or every other cycle. Each test case sets `rxSquelched` and `inRecovery` once and holds them until the case ends.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
  // Strobes from the control to the count datapath
  typedef struct packed {
    logic clear;   // drop the count back to zero
    logic countEn; // advance the count by one
  } cmrStrobe_t;
endpackage

// File: rtl/cmr_datapath.sv
module cmr_datapath
  import cmr_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmrStrobe_t        stb,
  input  logic [TIME_W-1:0] cmTime,
  output logic              zeroSet,
  output logic              reachOnTick
);
  localparam int CNT_W = TIME_W + 1;

  logic [TIME_W-1:0] cnt;
  logic [CNT_W-1:0]  nextCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.clear) begin
      cnt <= '0;
    end else if (stb.countEn) begin
      cnt <= nextCnt[TIME_W-1:0];
    end
  end

  // One extra bit so the comparison can never wrap
  always_comb begin
    nextCnt     = {1'b0, cnt} + CNT_W'(1);
    zeroSet     = (cmTime == '0);
    reachOnTick = (nextCnt >= {1'b0, cmTime});
  end
endmodule

// File: rtl/cmr_ctrl.sv
module cmr_ctrl
  import cmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       ts1Sent,
  input  logic       rxSquelched,
  input  logic       inRecovery,
  input  logic       zeroSet,
  input  logic       reachOnTick,
  output cmrStrobe_t stb,
  output logic       ts2Permit,
  output logic       timerDone
);
  logic ts1Seen;
  logic unsqSeen;
  logic armed;
  logic waiting;
  logic fire;

  always_comb begin
    armed       = ts1Seen & unsqSeen;
    waiting     = inRecovery & armed & ~ts2Permit;
    fire        = waiting & (zeroSet | (usTick & reachOnTick));
    stb.clear   = ~inRecovery;
    stb.countEn = waiting & usTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ts1Seen   <= 1'b0;
      unsqSeen  <= 1'b0;
      ts2Permit <= 1'b0;
      timerDone <= 1'b0;
    end else if (!inRecovery) begin
      ts1Seen   <= 1'b0;
      unsqSeen  <= 1'b0;
      ts2Permit <= 1'b0;
      timerDone <= 1'b0;
    end else begin
      ts1Seen   <= ts1Seen | ts1Sent;
      unsqSeen  <= unsqSeen | ~rxSquelched;
      ts2Permit <= ts2Permit | fire;
      timerDone <= fire;
    end
  end
endmodule

// File: rtl/cm_restore_gate.sv
module cm_restore_gate
  import cmr_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              ts1Sent,
  input  logic              rxSquelched,
  input  logic              inRecovery,
  input  logic [TIME_W-1:0] cmTime,
  output logic              ts2Permit,
  output logic              timerDone
);
  cmrStrobe_t stb;
  logic       zeroSet;
  logic       reachOnTick;

  cmr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .usTick      (usTick),
    .ts1Sent     (ts1Sent),
    .rxSquelched (rxSquelched),
    .inRecovery  (inRecovery),
    .zeroSet     (zeroSet),
    .reachOnTick (reachOnTick),
    .stb         (stb),
    .ts2Permit   (ts2Permit),
    .timerDone   (timerDone)
  );

  cmr_datapath #(.TIME_W(TIME_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cmTime      (cmTime),
    .zeroSet     (zeroSet),
    .reachOnTick (reachOnTick)
  );
endmodule

// File: rtl/cmr_gate_chk.sv
module cmr_gate_chk #(
  parameter int TIME_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              usTick,
  input logic              inRecovery,
  input logic [TIME_W-1:0] cmTime,
  input logic              ts2Permit,
  input logic              timerDone
);
  // R7: leaving recovery clears the outputs
  p_clear_on_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inRecovery |=> (!ts2Permit && !timerDone));

  // R6: the permit holds while recovery lasts
  p_permit_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ts2Permit && inRecovery) |=> ts2Permit);

  // R8: the done pulse lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    timerDone |=> !timerDone);

  // R8: the done pulse comes with the rise of the permit
  p_done_on_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ts2Permit) |-> timerDone);

  // R8: no done pulse without the permit
  p_done_has_permit_r8: assert property (@(posedge clk) disable iff (!rstN)
    timerDone |-> ts2Permit);

  // R4: with a nonzero setting, the permit rises only after a tick
  p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ts2Permit) && ($past(cmTime) != '0)) |-> $past(usTick));

  // R2: the permit rises only out of a recovery cycle
  p_rise_in_recovery_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ts2Permit) |-> $past(inRecovery));
endmodule

bind cm_restore_gate cmr_gate_chk #(.TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .usTick     (usTick),
  .inRecovery (inRecovery),
  .cmTime     (cmTime),
  .ts2Permit  (ts2Permit),
  .timerDone  (timerDone)
);

// File: tb/cm_restore_gate_tb.sv
module cm_restore_gate_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usTick = 1'b0;
  logic       ts1Sent = 1'b0;
  logic       rxSquelched = 1'b1;
  logic       inRecovery = 1'b0;
  logic [7:0] cmTime = 8'd0;
  logic       ts2Permit;
  logic       timerDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cm_restore_gate u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .usTick      (usTick),
    .ts1Sent     (ts1Sent),
    .rxSquelched (rxSquelched),
    .inRecovery  (inRecovery),
    .cmTime      (cmTime),
    .ts2Permit   (ts2Permit),
    .timerDone   (timerDone)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkBoth(input logic expP, input logic expD, input string req);
    check(ts2Permit, expP, req, "ts2Permit");
    check(timerDone, expD, req, "timerDone");
  endtask

  // One cycle out of recovery, then a fresh entry
  task automatic restart(input logic [7:0] setting);
    inRecovery  = 1'b0;
    rxSquelched = 1'b1;
    ts1Sent     = 1'b0;
    usTick      = 1'b0;
    cmTime      = setting;
    step();
    checkBoth(1'b0, 1'b0, "R7");
    inRecovery = 1'b1;
  endtask

  // Sweep case for one setting: event order and tick spacing are varied
  task automatic runCase(input int setting, input int order, input int period);
    int  ticks;
    bit  prevExp;
    bit  expP;
    restart(8'(setting));
    if (order == 0) begin
      ts1Sent = 1'b1; step(); ts1Sent = 1'b0;
      checkBoth(1'b0, 1'b0, "R3");
      rxSquelched = 1'b0; step();
    end else if (order == 1) begin
      rxSquelched = 1'b0; step();
      checkBoth(1'b0, 1'b0, "R3");
      ts1Sent = 1'b1; step(); ts1Sent = 1'b0;
    end else begin
      ts1Sent = 1'b1; rxSquelched = 1'b0; step(); ts1Sent = 1'b0;
    end
    checkBoth(1'b0, 1'b0, "R3");
    ticks   = 0;
    prevExp = 1'b0;
    for (int k = 0; ticks < setting + 2; k++) begin
      usTick = ((k % period) == (period - 1));
      step();
      if (usTick) ticks++;
      usTick = 1'b0;
      expP = (ticks >= setting);
      checkBoth(expP, expP && !prevExp, (setting == 0) ? "R5" : "R4");
      prevExp = expP;
    end
  endtask

  initial begin
    // R1: state right after reset
    #5;
    @(negedge clk);
    checkBoth(1'b0, 1'b0, "R1");
    step();
    rstN = 1'b1;
    step();
    checkBoth(1'b0, 1'b0, "R1");

    // R7: events outside recovery are not latched
    cmTime = 8'd1;
    ts1Sent = 1'b1; rxSquelched = 1'b0;
    step();
    ts1Sent = 1'b0; rxSquelched = 1'b1;
    inRecovery = 1'b1;
    for (int i = 0; i < 4; i++) begin
      usTick = 1'b1; step(); usTick = 1'b0;
      checkBoth(1'b0, 1'b0, "R7");
    end

    // R2: TS1 sent but the receiver stays squelched
    restart(8'd1);
    ts1Sent = 1'b1; step(); ts1Sent = 1'b0;
    for (int i = 0; i < 4; i++) begin
      usTick = 1'b1; step(); usTick = 1'b0;
      checkBoth(1'b0, 1'b0, "R2");
    end
    // R2: un-squelch alone, without a TS1
    restart(8'd1);
    rxSquelched = 1'b0;
    for (int i = 0; i < 4; i++) begin
      usTick = 1'b1; step(); usTick = 1'b0;
      checkBoth(1'b0, 1'b0, "R2");
    end

    // R4: a tick in the arming cycle is not counted
    restart(8'd1);
    ts1Sent = 1'b1; step(); ts1Sent = 1'b0;
    rxSquelched = 1'b0; usTick = 1'b1; step(); usTick = 1'b0;
    checkBoth(1'b0, 1'b0, "R4");
    step();
    checkBoth(1'b0, 1'b0, "R4");
    usTick = 1'b1; step(); usTick = 1'b0;
    checkBoth(1'b1, 1'b1, "R4");
    // R6: more events and ticks leave the permit set
    ts1Sent = 1'b1; usTick = 1'b1; step(); ts1Sent = 1'b0; usTick = 1'b0;
    checkBoth(1'b1, 1'b0, "R6");
    rxSquelched = 1'b1; step();
    checkBoth(1'b1, 1'b0, "R6");

    // R7: after an exit, the events must be seen again
    restart(8'd0);
    rxSquelched = 1'b0;
    step(); step();
    checkBoth(1'b0, 1'b0, "R7");

    // R9: every 8-bit setting, orders and tick spacings varied
    for (int s = 0; s < 256; s++) begin
      runCase(s, s % 3, (s % 2) + 1);
    end
    check(1'b1, 1'b1, "R9", "sweep completed");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule